// File: doc/BRIEF.md
# Two-Wire 16-bit Register Write Master

This block is a two-wire serial bus master that performs one register write in a slave sensor per request. A request carries a 16-bit register address and a 16-bit data word. The block frames them behind a fixed 8-bit device address byte that already includes the write bit, and sends five bytes in total. Each multi-byte field goes upper byte first, and every byte is sent MSB first.

The request port is a valid/ready handshake. `req_ready` is high only while the master is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high. A source that sees `req_ready` low must hold `req_valid`, `req_addr` and `req_data` steady until the transfer is taken. Nothing is buffered, so back-pressure lasts for the whole bus transaction.

On the bus side the block drives SCL as a push-pull output. SDA is open drain: the block has a drive-low enable and takes a sampled input through a two-flop synchronizer. The slave answers each byte with an acknowledge bit. A NACK sets an error flag, sends a stop condition at once and ends the transaction. A one-clock done pulse marks the end of every transaction, whether it succeeded or failed. The SCL rate comes from parameters and is split into four equal quarter phases per bit.

Top module: `sensor_reg_writer`

## Requirements
- R1: `req_ready` is 1 only while idle; it drops in the cycle after a request is accepted and stays 0 until the cycle after the done pulse.
- R2: Every transaction begins with a start condition: SDA falls while SCL is high, before the first SCL low phase.
- R3: The bytes go out in this order: device address `DEV_ADDR` (default 0x78), address bits 15:8, address bits 7:0, data bits 15:8, data bits 7:0. Each byte is MSB first, with a 1 sent by releasing SDA.
- R4: Outside the start and stop conditions, SDA changes only while SCL is low.
- R5: The master releases SDA (drive-low enable 0) during every ninth clock. It samples SDA at the midpoint of that clock's high phase, and a high level is a NACK.
- R6: After a NACK no further byte is sent: the master issues a stop, and `nack_o` is 1 at the done pulse.
- R7: Every transaction ends with a stop condition: SDA rises while SCL is high. SDA is then released and SCL stays high.
- R8: `done_o` is a single-cycle pulse, exactly once per accepted request. `nack_o` is cleared when a request is accepted and keeps its value after the done pulse until the next acceptance.
- R9: Each SCL low phase during a transaction lasts exactly 2*QTR system clocks, where QTR = SYS_CLK_HZ/(4*SCL_HZ).
- R10: After reset: SCL high, SDA released, `req_ready` 1, `done_o` 0, `nack_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Master idle, request can be accepted |
| req_addr | input | 16 | Register address of the write |
| req_data | input | 16 | Data word of the write |
| scl_o | output | 1 | Serial clock |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | SDA line level |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| nack_o | output | 1 | Last transaction ended on a NACK |

## Verification
The embedded assertions check the following on every cycle: SDA stays steady while SCL is high outside the start and stop states, SDA is released at each acknowledge sample point, a detected NACK leads straight to the stop state, `done_o` is never high for two cycles, and acceptance always drops `req_ready`. Other behaviours can only be shown by the bench's scenarios, which use a bus slave model: the byte contents and their order, truncation after a NACK on each of the five byte positions, the SCL low-phase width, and the single start and stop per transaction.

// File: rtl/twi_wr_pkg.sv
package twi_wr_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_BIT   = 3'd2,
    S_STOP  = 3'd3,
    S_DONE  = 3'd4
  } wr_state_t;

  localparam int unsigned CELL_BITS = 9;  // 8 data bits + acknowledge
  localparam logic [1:0]  Q_SETUP   = 2'd1;
  localparam logic [1:0]  Q_SAMPLE  = 2'd2;
  localparam logic [1:0]  Q_LAST    = 2'd3;
endpackage

// File: rtl/twi_qtr_timer.sv
module twi_qtr_timer #(
  parameter int unsigned QTR = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  output logic       tick,
  output logic [1:0] phase
);
  localparam int unsigned CW = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 2'd0;
    end else if (!run) begin
      cnt   <= '0;
      phase <= 2'd0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= phase + 2'd1;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // quarter phase only moves on a tick (R9)
  p_phase_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(phase));
endmodule

// File: rtl/twi_frame_shifter.sv
module twi_frame_shifter #(
  parameter logic [7:0]  DEV_ADDR = 8'h78,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              advance,
  output logic              tx_bit,
  output logic              on_ack,
  output logic              last_byte
);
  import twi_wr_pkg::*;

  localparam int unsigned FRAME_W = 8 + ADDR_W + DATA_W;
  localparam int unsigned NBYTES  = FRAME_W / 8;
  localparam int unsigned BYW     = $clog2(NBYTES + 1);
  localparam int unsigned BIW     = $clog2(CELL_BITS + 1);

  logic [FRAME_W-1:0] frame;
  logic [BIW-1:0]     bit_idx;
  logic [BYW-1:0]     byte_idx;

  assign tx_bit    = frame[FRAME_W-1];
  assign on_ack    = (bit_idx == BIW'(CELL_BITS - 1));
  assign last_byte = (byte_idx == BYW'(NBYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame    <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
    end else if (load) begin
      frame    <= {DEV_ADDR, addr, data};
      bit_idx  <= '0;
      byte_idx <= '0;
    end else if (advance) begin
      if (on_ack) begin
        bit_idx  <= '0;
        byte_idx <= byte_idx + BYW'(1);
      end else begin
        frame   <= {frame[FRAME_W-2:0], 1'b0};
        bit_idx <= bit_idx + BIW'(1);
      end
    end
  end

  // byte index never passes the frame length (R3)
  p_byte_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && on_ack && last_byte) |=> (load || byte_idx == BYW'(NBYTES)));
endmodule

// File: rtl/twi_wr_sequencer.sv
module twi_wr_sequencer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       tick,
  input  logic [1:0] phase,
  input  logic       tx_bit,
  input  logic       on_ack,
  input  logic       last_byte,
  input  logic       sda_in_s,
  output logic       load,
  output logic       advance,
  output logic       run,
  output logic       scl_o,
  output logic       sda_low_o,
  output logic       done_o,
  output logic       nack_o
);
  import twi_wr_pkg::*;

  wr_state_t state;
  logic      nack_seen;
  logic      cell_end;
  logic      sample;
  logic      scl_c;
  logic      sda_c;

  assign cell_end  = tick && (phase == Q_LAST);
  assign sample    = tick && (phase == Q_SAMPLE) && (state == S_BIT) && on_ack;
  assign req_ready = (state == S_IDLE);
  assign load      = req_ready && req_valid;
  assign advance   = (state == S_BIT) && cell_end;
  assign run       = (state == S_START) || (state == S_BIT) || (state == S_STOP);

  always_comb begin
    scl_c = 1'b1;
    sda_c = 1'b0;
    unique case (state)
      S_START: sda_c = phase[1];
      S_BIT: begin
        scl_c = phase[1];
        if (phase == 2'd0) sda_c = sda_low_o;
        else               sda_c = on_ack ? 1'b0 : ~tx_bit;
      end
      S_STOP: begin
        scl_c = phase[1];
        if (phase == 2'd0) sda_c = sda_low_o;
        else               sda_c = (phase != Q_LAST);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      nack_seen <= 1'b0;
      nack_o    <= 1'b0;
      done_o    <= 1'b0;
      scl_o     <= 1'b1;
      sda_low_o <= 1'b0;
    end else begin
      scl_o     <= scl_c;
      sda_low_o <= sda_c;
      done_o    <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          state  <= S_START;
          nack_o <= 1'b0;
        end
        S_START: if (cell_end) begin
          state     <= S_BIT;
          nack_seen <= 1'b0;
        end
        S_BIT: begin
          if (sample && sda_in_s) nack_seen <= 1'b1;
          if (cell_end && on_ack && (nack_seen || last_byte)) begin
            state  <= S_STOP;
            nack_o <= nack_seen;
          end
        end
        S_STOP: if (cell_end) begin
          state  <= S_DONE;
          done_o <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_ready_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_sda_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && state == S_BIT && $past(state) == S_BIT)
      |-> $stable(sda_low_o));

  p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (!sda_low_o && scl_o));

  p_nack_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && on_ack && nack_seen) |=> (state == S_STOP));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/sensor_reg_writer.sv
module sensor_reg_writer #(
  parameter int unsigned SYS_CLK_HZ = 50_000_000,
  parameter int unsigned SCL_HZ     = 100_000,
  parameter logic [7:0]  DEV_ADDR   = 8'h78
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_data,
  output logic        scl_o,
  output logic        sda_low_o,
  input  logic        sda_i,
  output logic        done_o,
  output logic        nack_o
);
  localparam int unsigned QTR_RAW = SYS_CLK_HZ / (4 * SCL_HZ);
  localparam int unsigned QTR     = (QTR_RAW < 2) ? 2 : QTR_RAW;

  logic       tick, run, load, advance;
  logic [1:0] phase;
  logic       tx_bit, on_ack, last_byte;
  logic [1:0] sda_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_sync <= 2'b11;
    else        sda_sync <= {sda_sync[0], sda_i};
  end

  twi_qtr_timer #(.QTR(QTR)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .phase(phase)
  );

  twi_frame_shifter #(.DEV_ADDR(DEV_ADDR), .ADDR_W(16), .DATA_W(16)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .addr(req_addr), .data(req_data),
    .advance(advance), .tx_bit(tx_bit), .on_ack(on_ack), .last_byte(last_byte)
  );

  twi_wr_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .tick(tick), .phase(phase), .tx_bit(tx_bit), .on_ack(on_ack),
    .last_byte(last_byte), .sda_in_s(sda_sync[1]), .load(load),
    .advance(advance), .run(run), .scl_o(scl_o), .sda_low_o(sda_low_o),
    .done_o(done_o), .nack_o(nack_o)
  );
endmodule

// File: tb/sensor_reg_writer_bench.sv
module sensor_reg_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 10;
  localparam int WATCHDOG   = 150000;
  localparam logic [7:0] DEV = 8'h78;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [15:0] req_addr = '0, req_data = '0;
  logic req_ready, scl, sda_low, done, nack;
  logic slv_low = 1'b0;
  wire  sda_line = !(sda_low || slv_low);

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_reg_writer #(.SYS_CLK_HZ(4_000_000), .SCL_HZ(100_000), .DEV_ADDR(DEV))
    u_sensor_reg_writer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .scl_o(scl),
      .sda_low_o(sda_low), .sda_i(sda_line), .done_o(done), .nack_o(nack));

  // slave model and monitors, sampled away from the active edge
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int   starts, stops, bitcnt, rx_n, nack_at, done_cnt, ready_err, low_run;
  int   low_err, ack_err, busy;
  logic ack_phase;
  logic [7:0] shreg;
  logic [7:0] rx [0:7];

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (busy != 0 && req_ready) ready_err++;
      if (!scl) low_run++;
      if (scl && !prev_scl) begin
        if (low_run != 2*QTR) low_err++;
        low_run = 0;
      end
      if (scl && prev_scl && prev_sda && !sda_line) begin
        starts++; bitcnt = 0; rx_n = 0; ack_phase = 1'b0;
      end
      if (scl && prev_scl && !prev_sda && sda_line) stops++;
      if (scl && !prev_scl) begin
        if (bitcnt < 8) begin
          shreg = {shreg[6:0], sda_line}; bitcnt++;
        end else begin
          if (sda_low) ack_err++;
          if (!slv_low && !sda_line) ack_err++;
          bitcnt = 0;
        end
      end
      if (!scl && prev_scl) begin
        if (ack_phase) begin
          slv_low = 1'b0; ack_phase = 1'b0;
        end else if (bitcnt == 8) begin
          if (rx_n < 8) rx[rx_n] = shreg;
          slv_low = (rx_n != nack_at);
          ack_phase = 1'b1;
          rx_n++;
        end
      end
      prev_scl = scl;
      prev_sda = sda_line;
    end
  end

  function automatic logic [7:0] exp_byte(input logic [15:0] a, input logic [15:0] d,
                                          input int k);
    case (k)
      0: return DEV;
      1: return a[15:8];
      2: return a[7:0];
      3: return d[15:8];
      default: return d[7:0];
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic [15:0] a, input logic [15:0] d, input int nk);
    int exp_n;
    logic bytes_ok;
    starts = 0; stops = 0; done_cnt = 0; ready_err = 0; low_err = 0; ack_err = 0;
    rx_n = 0; nack_at = nk;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; busy = 1;
    check(!req_ready, "R1 ready low after accept", req_ready, 0);
    while (!done) @(negedge clk);
    busy = 0;
    check(nack == (nk < 5), "R6 nack at done", nack, nk < 5);
    @(negedge clk);
    exp_n = (nk < 5) ? nk + 1 : 5;
    check(rx_n == exp_n, "R6 byte count", rx_n, exp_n);
    bytes_ok = 1'b1;
    for (int k = 0; k < exp_n && k < rx_n; k++)
      if (rx[k] != exp_byte(a, d, k)) bytes_ok = 1'b0;
    check(bytes_ok, "R3 byte contents", rx[0], exp_byte(a, d, 0));
    check(starts == 1, "R2 start count (R4 no extra)", starts, 1);
    check(stops == 1, "R7 stop count (R4 no extra)", stops, 1);
    check(scl && !sda_low, "R7 bus released after stop", {scl, sda_low}, 2);
    check(done_cnt == 1, "R8 done pulse count", done_cnt, 1);
    check(ready_err == 0, "R1 ready while busy", ready_err, 0);
    check(req_ready, "R1 ready back after done", req_ready, 1);
    check(low_err == 0, "R9 scl low width", low_err, 0);
    check(ack_err == 0, "R5 sda released at ack", ack_err, 0);
    repeat (5) @(negedge clk);
    check(nack == (nk < 5), "R8 nack held", nack, nk < 5);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    busy = 0; nack_at = 9; low_run = 0; ack_phase = 1'b0; bitcnt = 0; shreg = '0;
    repeat (3) @(negedge clk);
    check(scl && !sda_low && req_ready && !done && !nack, "R10 reset state",
          {scl, sda_low, req_ready, done, nack}, 5'b10100);
    rst_n = 1'b1;
    @(negedge clk);
    run_txn(16'h0000, 16'h0000, 5);
    run_txn(16'hFFFF, 16'hFFFF, 5);
    run_txn(16'h3A5C, 16'hC3A5, 5);
    for (int k = 0; k < 5; k++) run_txn(16'h1234, 16'hBEEF, k);
    for (int i = 0; i < 12; i++) begin
      logic [15:0] ra, rd;
      int nk;
      ra = 16'($urandom); rd = 16'($urandom);
      nk = (($urandom % 4) == 0) ? int'($urandom % 5) : 5;
      run_txn(ra, rd, nk);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule